// File: doc/BRIEF.md
# Memory-to-Stream DMA Channel

This block is a single-channel engine that copies a contiguous region of memory onto a packet stream. Software uses a small AXI4-Lite register window to program it: a control word, a status word, a source address and a byte count. Writing a non-zero byte count while the channel is enabled and idle starts the copy. The engine issues AXI4 incrementing read bursts and forwards each returned beat onto an AXI4-Stream output. The beat that carries the last programmed byte is marked as the end of the packet. Sticky completion and error flags drive one interrupt line through separate enables.

The stream output follows valid/ready rules. `st_tvalid` is raised only while a read beat is present. Once raised, it stays high with `st_tdata`, `st_tkeep` and `st_tlast` unchanged until `st_tready` accepts the beat. While `st_tready` is low, the engine holds `m_rready` low, so back-pressure passes straight to memory with no buffering in between. The read channel has exactly one burst outstanding at a time. The source address must be aligned to the beat size (DATA_W/8 bytes); the low address bits are ignored.

Top module: `mm2s_dma_channel`

## Requirements
- R1: After reset the status word (offset 0x4) reads 0x3: bit 0 idle = 1, bit 1 halted = 1, bit 2 done = 0, bit 3 error = 0. `irq`, `st_tvalid` and `m_arvalid` are low.
- R2: The control word at offset 0x0 has bit 0 run, bit 1 done-interrupt enable and bit 2 error-interrupt enable. A length write (offset 0xC) while run is 0 starts nothing: no read address is issued and the status stays idle and halted.
- R3: The source (offset 0x8) and control words may be written in any order. A non-zero length write with run = 1 and the channel idle starts a transfer of ceil(len/BPB) beats.
- R4: Every read burst has ARBURST = INCR (2'b01), ARSIZE = log2(BPB) and at most MAX_BURST beats. The address and length stay stable until accepted.
- R5: No read burst crosses a 4096-byte address boundary.
- R6: The stream carries the memory words in address order. `st_tlast` is high on the final beat only.
- R7: `st_tkeep` is all ones on every beat except a partial final beat. That beat has the low (len mod BPB) bits set.
- R8: With `st_tready` low, no beat is lost or duplicated and the transferred data is unchanged.
- R9: Status bit 2 (done) is set when the last beat of a transfer is accepted and stays set until written with 1. `irq` follows done AND its enable.
- R10: A read response of SLVERR or DECERR (RRESP[1] = 1) sets status bit 3 (error) and clears the run bit. That beat and the rest of its burst are discarded, and no further burst is issued.
- R11: `irq` follows the error flag AND the error enable. A flag whose enable is 0 does not raise `irq`.
- R12: A length write of 0, or any length write while a transfer is in progress, is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_awaddr | input | 4 | Register write address |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_wdata | input | 32 | Register write data |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_bresp | output | 2 | Write response (always OKAY) |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_araddr | input | 4 | Register read address |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_rdata | output | 32 | Register read data |
| s_rresp | output | 2 | Read response (always OKAY) |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| m_araddr | output | ADDR_W | Memory burst start address |
| m_arlen | output | 8 | Burst beats minus one |
| m_arsize | output | 3 | Log2 of bytes per beat |
| m_arburst | output | 2 | Burst type (INCR) |
| m_arvalid | output | 1 | Burst request valid |
| m_arready | input | 1 | Burst request ready |
| m_rdata | input | DATA_W | Memory read data |
| m_rresp | input | 2 | Memory read response |
| m_rlast | input | 1 | Last beat of burst |
| m_rvalid | input | 1 | Read data valid |
| m_rready | output | 1 | Read data ready |
| st_tdata | output | DATA_W | Stream data |
| st_tkeep | output | DATA_W/8 | Stream byte enables |
| st_tlast | output | 1 | End of packet |
| st_tvalid | output | 1 | Stream beat valid |
| st_tready | input | 1 | Stream beat ready |
| irq | output | 1 | Interrupt request |

## Verification
A wrong remaining-beat count shows at the stream pins on the final beat of the packet. It appears as `st_tlast` or a narrowed `st_tkeep` one beat early or late, or as a packet that never terminates. A wrong page or burst computation shows on the very first `m_arvalid` of a transfer that starts near a 4 KB boundary, or on a burst count that differs from the expected split. Flag or run-bit corruption shows on `irq`, or on the next status read, within a cycle of the completing or failing beat.

// File: rtl/mm2s_pkg.sv
package mm2s_pkg;
  localparam logic [1:0] REG_CTRL = 2'd0;
  localparam logic [1:0] REG_STAT = 2'd1;
  localparam logic [1:0] REG_SRC  = 2'd2;
  localparam logic [1:0] REG_LEN  = 2'd3;

  localparam int PAGE_BYTES = 4096;

  typedef enum logic [1:0] {
    ENG_IDLE,
    ENG_ADDR,
    ENG_DATA
  } eng_state_t;
endpackage

// File: rtl/mm2s_csr.sv
module mm2s_csr
  import mm2s_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        s_awaddr,
  input  logic              s_awvalid,
  output logic              s_awready,
  input  logic [31:0]       s_wdata,
  input  logic              s_wvalid,
  output logic              s_wready,
  output logic [1:0]        s_bresp,
  output logic              s_bvalid,
  input  logic              s_bready,
  input  logic [3:0]        s_araddr,
  input  logic              s_arvalid,
  output logic              s_arready,
  output logic [31:0]       s_rdata,
  output logic [1:0]        s_rresp,
  output logic              s_rvalid,
  input  logic              s_rready,
  input  logic              busy,
  input  logic              set_done,
  input  logic              set_err,
  output logic [ADDR_W-1:0] src_addr,
  output logic [LEN_W-1:0]  start_len,
  output logic              start,
  output logic              irq
);
  logic             run_q, done_ie_q, err_ie_q;
  logic             done_q, err_q;
  logic [LEN_W-1:0] len_q;
  logic             wr_fire, rd_fire;
  logic [1:0]       wsel;

  assign s_awready = s_awvalid && s_wvalid && !s_bvalid;
  assign s_wready  = s_awready;
  assign wr_fire   = s_awready;
  assign wsel      = s_awaddr[3:2];
  assign s_bresp   = 2'b00;
  assign s_rresp   = 2'b00;
  assign s_arready = !s_rvalid;
  assign rd_fire   = s_arvalid && s_arready;

  assign start = wr_fire && (wsel == REG_LEN) && run_q && !busy &&
                 (s_wdata[LEN_W-1:0] != '0);
  assign start_len = s_wdata[LEN_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s_bvalid <= 1'b0;
    end else if (wr_fire) begin
      s_bvalid <= 1'b1;
    end else if (s_bready) begin
      s_bvalid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q     <= 1'b0;
      done_ie_q <= 1'b0;
      err_ie_q  <= 1'b0;
      src_addr  <= '0;
      len_q     <= '0;
    end else begin
      if (wr_fire && wsel == REG_CTRL) begin
        run_q     <= s_wdata[0];
        done_ie_q <= s_wdata[1];
        err_ie_q  <= s_wdata[2];
      end
      if (set_err) run_q <= 1'b0;
      if (wr_fire && wsel == REG_SRC) src_addr <= s_wdata[ADDR_W-1:0];
      if (start) len_q <= start_len;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      if (wr_fire && wsel == REG_STAT && s_wdata[2]) done_q <= 1'b0;
      if (wr_fire && wsel == REG_STAT && s_wdata[3]) err_q  <= 1'b0;
      if (set_done) done_q <= 1'b1;
      if (set_err)  err_q  <= 1'b1;
    end
  end

  assign irq = (done_q && done_ie_q) || (err_q && err_ie_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s_rvalid <= 1'b0;
      s_rdata  <= '0;
    end else if (rd_fire) begin
      s_rvalid <= 1'b1;
      case (s_araddr[3:2])
        REG_CTRL: s_rdata <= {29'd0, err_ie_q, done_ie_q, run_q};
        REG_STAT: s_rdata <= {28'd0, err_q, done_q, !run_q, !busy};
        REG_SRC:  s_rdata <= 32'(src_addr);
        default:  s_rdata <= 32'(len_q);
      endcase
    end else if (s_rready) begin
      s_rvalid <= 1'b0;
    end
  end

  assert_err_halts_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_q) |-> !run_q);
  assert_irq_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && done_ie_q) |-> irq);
  assert_irq_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!done_q && !err_q) |-> !irq);
endmodule

// File: rtl/mm2s_burst_gen.sv
module mm2s_burst_gen
  import mm2s_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int CNT_W     = 17,
  parameter int BPB       = 4,
  parameter int MAX_BURST = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [CNT_W-1:0]  start_beats,
  input  logic              burst_end,
  input  logic              err_beat,
  output logic [ADDR_W-1:0] m_araddr,
  output logic [7:0]        m_arlen,
  output logic [2:0]        m_arsize,
  output logic [1:0]        m_arburst,
  output logic              m_arvalid,
  input  logic              m_arready,
  output logic              busy,
  output logic              data_phase,
  output logic              done_pulse
);
  localparam int BPB_LG = $clog2(BPB);

  eng_state_t        state_q;
  logic [ADDR_W-1:0] cur_addr;
  logic [CNT_W-1:0]  beats_left;
  logic              err_hold;
  logic              err_now;
  logic [31:0]       to_page, left_w, burst_w;

  assign to_page = (32'(PAGE_BYTES) - {20'd0, cur_addr[11:0]}) >> BPB_LG;
  assign left_w  = 32'(beats_left);

  always_comb begin
    burst_w = 32'(MAX_BURST);
    if (left_w < burst_w)  burst_w = left_w;
    if (to_page < burst_w) burst_w = to_page;
  end

  assign m_araddr   = cur_addr;
  assign m_arlen    = 8'(burst_w - 32'd1);
  assign m_arsize   = 3'(BPB_LG);
  assign m_arburst  = 2'b01;
  assign m_arvalid  = (state_q == ENG_ADDR);
  assign busy       = (state_q != ENG_IDLE);
  assign data_phase = (state_q == ENG_DATA);
  assign err_now    = err_hold || err_beat;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= ENG_IDLE;
      cur_addr   <= '0;
      beats_left <= '0;
      err_hold   <= 1'b0;
      done_pulse <= 1'b0;
    end else begin
      done_pulse <= 1'b0;
      case (state_q)
        ENG_IDLE: if (start) begin
          cur_addr   <= {start_addr[ADDR_W-1:BPB_LG], {BPB_LG{1'b0}}};
          beats_left <= start_beats;
          err_hold   <= 1'b0;
          state_q    <= ENG_ADDR;
        end
        ENG_ADDR: if (m_arready) begin
          cur_addr   <= cur_addr + ADDR_W'(burst_w << BPB_LG);
          beats_left <= beats_left - CNT_W'(burst_w);
          state_q    <= ENG_DATA;
        end
        default: begin
          if (err_beat) err_hold <= 1'b1;
          if (burst_end) begin
            if (err_now || beats_left == '0) begin
              state_q    <= ENG_IDLE;
              done_pulse <= !err_now;
            end else begin
              state_q <= ENG_ADDR;
            end
          end
        end
      endcase
    end
  end

  assert_burst_max_R4: assert property (@(posedge clk) disable iff (!rst_n)
    m_arvalid |-> (32'(m_arlen) < 32'(MAX_BURST)));
  assert_ar_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (m_arvalid && !m_arready) |=> (m_arvalid && $stable(m_araddr) && $stable(m_arlen)));
  assert_no_page_cross_R5: assert property (@(posedge clk) disable iff (!rst_n)
    m_arvalid |-> (({20'd0, m_araddr[11:0]} + ((32'(m_arlen) + 32'd1) << BPB_LG))
                   <= 32'(PAGE_BYTES)));
endmodule

// File: rtl/mm2s_stream_out.sv
module mm2s_stream_out #(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 17,
  parameter int LEN_W  = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [CNT_W-1:0]    start_beats,
  input  logic [LEN_W-1:0]    start_len,
  input  logic                data_phase,
  input  logic [DATA_W-1:0]   m_rdata,
  input  logic [1:0]          m_rresp,
  input  logic                m_rlast,
  input  logic                m_rvalid,
  output logic                m_rready,
  output logic [DATA_W-1:0]   st_tdata,
  output logic [DATA_W/8-1:0] st_tkeep,
  output logic                st_tlast,
  output logic                st_tvalid,
  input  logic                st_tready,
  output logic                burst_end,
  output logic                err_beat
);
  localparam int BPB    = DATA_W / 8;
  localparam int BPB_LG = $clog2(BPB);

  logic [CNT_W-1:0] remain_q;
  logic [BPB-1:0]   last_keep_q;
  logic             drop_q;
  logic             bad_resp;
  logic             discard;
  logic [LEN_W-1:0] rem_bytes;

  assign rem_bytes = start_len & LEN_W'(BPB - 1);
  assign bad_resp  = m_rresp[1];
  assign discard   = drop_q || bad_resp;

  assign st_tdata  = m_rdata;
  assign st_tlast  = (remain_q == CNT_W'(1));
  assign st_tkeep  = st_tlast ? last_keep_q : '1;
  assign st_tvalid = data_phase && m_rvalid && !discard;
  assign m_rready  = data_phase && (discard || st_tready);
  assign burst_end = m_rvalid && m_rready && m_rlast;
  assign err_beat  = m_rvalid && m_rready && bad_resp && !drop_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      remain_q    <= '0;
      last_keep_q <= '1;
      drop_q      <= 1'b0;
    end else if (start) begin
      remain_q    <= start_beats;
      last_keep_q <= (rem_bytes == '0) ? '1 : BPB'((1 << rem_bytes) - 1);
      drop_q      <= 1'b0;
    end else begin
      if (st_tvalid && st_tready) remain_q <= remain_q - CNT_W'(1);
      if (err_beat) drop_q <= 1'b1;
    end
  end

  assert_full_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_tvalid && !st_tlast) |-> (&st_tkeep));
  assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_tvalid && !st_tready) |=> st_tvalid);
  assert_one_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_tvalid && st_tready && st_tlast) |=> !st_tvalid || start);
endmodule

// File: rtl/mm2s_dma_channel.sv
module mm2s_dma_channel #(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int LEN_W     = 16,
  parameter int MAX_BURST = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [3:0]          s_awaddr,
  input  logic                s_awvalid,
  output logic                s_awready,
  input  logic [31:0]         s_wdata,
  input  logic                s_wvalid,
  output logic                s_wready,
  output logic [1:0]          s_bresp,
  output logic                s_bvalid,
  input  logic                s_bready,
  input  logic [3:0]          s_araddr,
  input  logic                s_arvalid,
  output logic                s_arready,
  output logic [31:0]         s_rdata,
  output logic [1:0]          s_rresp,
  output logic                s_rvalid,
  input  logic                s_rready,
  output logic [ADDR_W-1:0]   m_araddr,
  output logic [7:0]          m_arlen,
  output logic [2:0]          m_arsize,
  output logic [1:0]          m_arburst,
  output logic                m_arvalid,
  input  logic                m_arready,
  input  logic [DATA_W-1:0]   m_rdata,
  input  logic [1:0]          m_rresp,
  input  logic                m_rlast,
  input  logic                m_rvalid,
  output logic                m_rready,
  output logic [DATA_W-1:0]   st_tdata,
  output logic [DATA_W/8-1:0] st_tkeep,
  output logic                st_tlast,
  output logic                st_tvalid,
  input  logic                st_tready,
  output logic                irq
);
  localparam int BPB    = DATA_W / 8;
  localparam int BPB_LG = $clog2(BPB);
  localparam int CNT_W  = LEN_W + 1;

  logic              busy, data_phase, done_pulse, start;
  logic              burst_end, err_beat;
  logic [ADDR_W-1:0] src_addr;
  logic [LEN_W-1:0]  start_len;
  logic [CNT_W-1:0]  start_beats;

  assign start_beats = (CNT_W'(start_len) + CNT_W'(BPB - 1)) >> BPB_LG;

  mm2s_csr #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) csr_i (
    .clk(clk), .rst_n(rst_n),
    .s_awaddr(s_awaddr), .s_awvalid(s_awvalid), .s_awready(s_awready),
    .s_wdata(s_wdata), .s_wvalid(s_wvalid), .s_wready(s_wready),
    .s_bresp(s_bresp), .s_bvalid(s_bvalid), .s_bready(s_bready),
    .s_araddr(s_araddr), .s_arvalid(s_arvalid), .s_arready(s_arready),
    .s_rdata(s_rdata), .s_rresp(s_rresp), .s_rvalid(s_rvalid), .s_rready(s_rready),
    .busy(busy), .set_done(done_pulse), .set_err(err_beat),
    .src_addr(src_addr), .start_len(start_len), .start(start), .irq(irq)
  );

  mm2s_burst_gen #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .BPB(BPB), .MAX_BURST(MAX_BURST)) gen_i (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(src_addr),
    .start_beats(start_beats), .burst_end(burst_end), .err_beat(err_beat),
    .m_araddr(m_araddr), .m_arlen(m_arlen), .m_arsize(m_arsize),
    .m_arburst(m_arburst), .m_arvalid(m_arvalid), .m_arready(m_arready),
    .busy(busy), .data_phase(data_phase), .done_pulse(done_pulse)
  );

  mm2s_stream_out #(.DATA_W(DATA_W), .CNT_W(CNT_W), .LEN_W(LEN_W)) out_i (
    .clk(clk), .rst_n(rst_n), .start(start), .start_beats(start_beats),
    .start_len(start_len), .data_phase(data_phase),
    .m_rdata(m_rdata), .m_rresp(m_rresp), .m_rlast(m_rlast),
    .m_rvalid(m_rvalid), .m_rready(m_rready),
    .st_tdata(st_tdata), .st_tkeep(st_tkeep), .st_tlast(st_tlast),
    .st_tvalid(st_tvalid), .st_tready(st_tready),
    .burst_end(burst_end), .err_beat(err_beat)
  );
endmodule

// File: tb/mm2s_dma_channel_tb.sv
module mm2s_dma_channel_tb_top;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [31:0] src;
    logic [15:0] len;
    logic        bp;
  } vec_t;

  localparam vec_t VECS [5] = '{
    '{src: 32'h0000_0100, len: 16'd16,  bp: 1'b0},
    '{src: 32'h0000_0FF0, len: 16'd40,  bp: 1'b1},
    '{src: 32'h0000_2000, len: 16'd130, bp: 1'b1},
    '{src: 32'h0000_3004, len: 16'd1,   bp: 1'b0},
    '{src: 32'h0000_4FFC, len: 16'd7,   bp: 1'b1}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [3:0]  s_awaddr = '0, s_araddr = '0;
  logic        s_awvalid = 1'b0, s_wvalid = 1'b0, s_arvalid = 1'b0;
  logic [31:0] s_wdata = '0;
  logic        s_awready, s_wready, s_bvalid, s_arready, s_rvalid;
  logic [1:0]  s_bresp, s_rresp;
  logic [31:0] s_rdata;
  logic [31:0] m_araddr;
  logic [7:0]  m_arlen;
  logic [2:0]  m_arsize;
  logic [1:0]  m_arburst;
  logic        m_arvalid, m_arready, m_rready;
  logic [31:0] m_rdata = '0;
  logic [1:0]  m_rresp = '0;
  logic        m_rlast = 1'b0, m_rvalid = 1'b0;
  logic [31:0] st_tdata;
  logic [3:0]  st_tkeep;
  logic        st_tlast, st_tvalid, irq;
  logic        st_tready = 1'b1;

  mm2s_dma_channel dut_i (
    .clk(clk), .rst_n(rst_n),
    .s_awaddr(s_awaddr), .s_awvalid(s_awvalid), .s_awready(s_awready),
    .s_wdata(s_wdata), .s_wvalid(s_wvalid), .s_wready(s_wready),
    .s_bresp(s_bresp), .s_bvalid(s_bvalid), .s_bready(1'b1),
    .s_araddr(s_araddr), .s_arvalid(s_arvalid), .s_arready(s_arready),
    .s_rdata(s_rdata), .s_rresp(s_rresp), .s_rvalid(s_rvalid), .s_rready(1'b1),
    .m_araddr(m_araddr), .m_arlen(m_arlen), .m_arsize(m_arsize),
    .m_arburst(m_arburst), .m_arvalid(m_arvalid), .m_arready(m_arready),
    .m_rdata(m_rdata), .m_rresp(m_rresp), .m_rlast(m_rlast),
    .m_rvalid(m_rvalid), .m_rready(m_rready),
    .st_tdata(st_tdata), .st_tkeep(st_tkeep), .st_tlast(st_tlast),
    .st_tvalid(st_tvalid), .st_tready(st_tready), .irq(irq)
  );

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    return {a[15:0] ^ 16'hC3A5, a[15:0]};
  endfunction

  // memory model: one burst at a time, error injected at err_addr
  logic [31:0] err_addr = 32'hFFFF_FFF0;
  logic        mem_busy = 1'b0;
  logic [31:0] mem_addr = '0;
  logic [7:0]  mem_left = '0;
  assign m_arready = !mem_busy;
  always @(posedge clk) begin
    if (!mem_busy) begin
      if (m_arvalid) begin
        mem_busy <= 1'b1;
        mem_addr <= m_araddr + 32'd4;
        mem_left <= m_arlen;
        m_rvalid <= 1'b1;
        m_rdata  <= mem_word(m_araddr);
        m_rresp  <= (m_araddr == err_addr) ? 2'b10 : 2'b00;
        m_rlast  <= (m_arlen == 8'd0);
      end
    end else if (m_rvalid && m_rready) begin
      if (m_rlast) begin
        mem_busy <= 1'b0;
        m_rvalid <= 1'b0;
        m_rlast  <= 1'b0;
      end else begin
        mem_addr <= mem_addr + 32'd4;
        mem_left <= mem_left - 8'd1;
        m_rdata  <= mem_word(mem_addr);
        m_rresp  <= (mem_addr == err_addr) ? 2'b10 : 2'b00;
        m_rlast  <= (mem_left == 8'd1);
      end
    end
  end

  // monitors
  logic [31:0] cap_data [256];
  logic [3:0]  cap_keep [256];
  logic        cap_last [256];
  int          cap_n = 0, ar_n = 0, bad_ar = 0;
  always @(posedge clk) begin
    if (st_tvalid && st_tready) begin
      cap_data[cap_n[7:0]] <= st_tdata;
      cap_keep[cap_n[7:0]] <= st_tkeep;
      cap_last[cap_n[7:0]] <= st_tlast;
      cap_n <= cap_n + 1;
    end
    if (m_arvalid && m_arready) begin
      ar_n <= ar_n + 1;
      if (m_arlen > 8'd15 || m_arsize != 3'd2 || m_arburst != 2'b01 ||
          ({20'd0, m_araddr[11:0]} + ((32'(m_arlen) + 1) << 2)) > 32'd4096)
        bad_ar <= bad_ar + 1;
    end
  end

  // back-pressure: 0 none, 1 pseudo-random, 2 held off
  int         bp_mode = 0;
  logic [7:0] lfsr = 8'h5B;
  always @(negedge clk) begin
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    st_tready <= (bp_mode == 0) ? 1'b1 : (bp_mode == 1) ? lfsr[0] : 1'b0;
  end

  int checks = 0, fails = 0;
  bit done_flag = 1'b0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic lwrite(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    s_awaddr = a; s_wdata = d; s_awvalid = 1'b1; s_wvalid = 1'b1;
    while (!s_awready) @(negedge clk);
    @(negedge clk);
    s_awvalid = 1'b0; s_wvalid = 1'b0;
  endtask

  task automatic lread(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    s_araddr = a; s_arvalid = 1'b1;
    while (!s_arready) @(negedge clk);
    @(negedge clk);
    s_arvalid = 1'b0;
    d = s_rdata;
  endtask

  task automatic wait_stat(input int bitno);
    logic [31:0] st;
    st = '0;
    for (int k = 0; k < 3000; k++) begin
      lread(4'h4, st);
      if (st[bitno]) break;
    end
  endtask

  function automatic int exp_bursts(input logic [31:0] src, input int len);
    int a, b, n, c, pg;
    a = int'(src & 32'hFFFF_FFFC); b = (len + 3) / 4; c = 0;
    while (b > 0) begin
      pg = (4096 - (a % 4096)) / 4;
      n = 16;
      if (b < n) n = b;
      if (pg < n) n = pg;
      a += 4 * n; b -= n; c++;
    end
    return c;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    int base_c, base_a, nb, rem;
    logic [3:0] ek;
    repeat (4) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 irq", 32'(irq), 0);
    check("R1 tvalid/arvalid", {30'd0, st_tvalid, m_arvalid}, 0);
    lread(4'h4, rd);
    check("R1 status", rd, 32'h3);

    // R2 length write without run
    lwrite(4'h8, 32'h100);
    base_a = ar_n;
    lwrite(4'hC, 32'd16);
    repeat (30) @(negedge clk);
    check("R2 no burst", ar_n - base_a, 0);
    lread(4'h4, rd);
    check("R2 status", rd, 32'h3);

    // R12 zero length with run set
    lwrite(4'h0, 32'h3);
    lwrite(4'hC, 32'd0);
    repeat (20) @(negedge clk);
    check("R12 zero length", ar_n - base_a, 0);

    // table of transfers: R3 R4 R5 R6 R7 R8 R9
    foreach (VECS[i]) begin
      base_c = cap_n; base_a = ar_n;
      bp_mode = VECS[i].bp ? 1 : 0;
      lwrite(4'h8, VECS[i].src);
      lwrite(4'hC, 32'(VECS[i].len));
      wait_stat(2);
      repeat (2) @(negedge clk);
      nb = (int'(VECS[i].len) + 3) / 4;
      rem = int'(VECS[i].len) % 4;
      check("R3 beat count", cap_n - base_c, nb);
      check("R5 burst split", ar_n - base_a, exp_bursts(VECS[i].src, int'(VECS[i].len)));
      check("R4 burst fields", bad_ar, 0);
      for (int j = 0; j < nb; j++) begin
        ek = (j == nb - 1 && rem != 0) ? 4'((1 << rem) - 1) : 4'hF;
        check("R6/R8 data", cap_data[base_c + j],
              mem_word((VECS[i].src & 32'hFFFF_FFFC) + 32'(4 * j)));
        check("R7 keep", 32'(cap_keep[base_c + j]), 32'(ek));
        check("R6 last", 32'(cap_last[base_c + j]), 32'(j == nb - 1));
      end
      check("R9 irq on done", 32'(irq), 1);
      lwrite(4'h4, 32'h4);
      lread(4'h4, rd);
      check("R9 w1c done", rd & 32'hC, 0);
      check("R9 irq cleared", 32'(irq), 0);
    end
    bp_mode = 0;

    // R12 length rewrite while busy
    base_c = cap_n; base_a = ar_n;
    bp_mode = 2;
    lwrite(4'h8, 32'h6000);
    lwrite(4'hC, 32'd32);
    repeat (10) @(negedge clk);
    lwrite(4'hC, 32'd8);
    bp_mode = 0;
    wait_stat(2);
    repeat (2) @(negedge clk);
    check("R12 busy rewrite beats", cap_n - base_c, 8);
    check("R12 busy rewrite bursts", ar_n - base_a, 1);
    lwrite(4'h4, 32'h4);

    // R11 done flag with its enable off
    lwrite(4'h0, 32'h1);
    lwrite(4'hC, 32'd8);
    wait_stat(2);
    check("R11 masked done", 32'(irq), 0);
    lwrite(4'h4, 32'h4);

    // R10/R11 error response mid-burst
    base_c = cap_n; base_a = ar_n;
    err_addr = 32'h5008;
    lwrite(4'h0, 32'h5);
    lwrite(4'h8, 32'h5000);
    lwrite(4'hC, 32'd40);
    wait_stat(3);
    repeat (20) @(negedge clk);
    check("R10 beats before error", cap_n - base_c, 2);
    check("R10 single burst", ar_n - base_a, 1);
    lread(4'h0, rd);
    check("R10 run cleared", rd & 32'h1, 0);
    lread(4'h4, rd);
    check("R10 status err not done", rd, 32'hB);
    check("R11 irq on error", 32'(irq), 1);
    lwrite(4'h4, 32'h8);
    check("R11 irq after w1c", 32'(irq), 0);

    done_flag = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule